// File: doc/BRIEF.md
# Dual-Channel Simultaneous Sampling Sequencer

This block paces a two-channel converter that samples both of its inputs at the same instant. Three start sources share one request path: a PWM event, a software write and an external pin. When the sequencer is idle, any of them starts a conversion. The sequencer then waits two and a half converter clocks and drives a sample/hold pulse whose width comes from a 4-bit acquisition setting. Both channels are sampled on the falling edge of that pulse. The A-channel code and the B-channel code are then taken from input ports into their own result registers, one converter clock apart. An interrupt flag follows two clocks after the B-channel update.

All timing runs from one clock `clk` at twice the converter clock rate. This makes the half-period trigger delay exact. The converter clock is derived from `clk` and driven out. A single 3-bit pair index drives the analog multiplexer, so channel k of A is always paired with channel k of B. A continuous-mode input starts the next sample/hold pulse after each sampling edge, without a further request. A request that arrives while the sequencer is busy is dropped, and the drop is recorded in a sticky flag.

Top module: `simul_adc_seq`

## Requirements
- R1: When the sequencer is idle, a high level on `trig_pwm_i`, `trig_sw_i` or `trig_ext_i` at a rising `clk` edge (edge E) starts a conversion. `sh_o` is low after edge E+4 and high after edge E+5, which is 2.5 converter clocks.
- R2: `sh_o` stays high for exactly 2*(1+acq) `clk` cycles, where acq is the 4-bit `acq_i` value latched at the start. Its fall marks the sampling edge S.
- R3: `res_a_o` loads the value `code_a_i` has at edge S+8 (4 converter clocks), and `res_b_o` loads the value `code_b_i` has at edge S+10 (5 converter clocks). Between loads both registers hold their values.
- R4: `pair_o` takes `pair_i` at the accepting edge and holds it through the whole sample/hold pulse, even if `pair_i` changes.
- R5: While `cont_i` is high at a sampling edge, `acq_i` and `pair_i` are latched again at that edge. `sh_o` rises again after edge S+4, so successive sampling edges are 2*(3+acq) `clk` cycles apart.
- R6: If `cont_i` is low at a sampling edge S, the sequencer stays busy through edge S+10. A request at edge S+10 is ignored, and a request at edge S+11 is accepted.
- R7: `irq_o` is set by the edge two cycles after each `res_b_o` load, that is edge S+12. It stays set until `clr_i` is high at an edge, and it is low before that set edge if it was cleared earlier.
- R8: A request that arrives while the sequencer is busy leaves the running sample/hold timing and the results unchanged. It sets `ovf_o`, which stays high until `clr_i` clears it.
- R9: `adc_clk_o` is 0 in reset and toggles on every `clk` edge after reset.
- R10: While `rst_n` is low, `sh_o`, `irq_o`, `ovf_o`, `pair_o`, `res_a_o` and `res_b_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock at twice the converter clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_pwm_i | input | 1 | Start request from a PWM event |
| trig_sw_i | input | 1 | Start request from a software write |
| trig_ext_i | input | 1 | Start request from an external pin |
| cont_i | input | 1 | Continuous mode: restart after each sampling edge |
| acq_i | input | 4 | Acquisition setting; pulse width is 1+acq converter clocks |
| pair_i | input | 3 | Channel pair index k, selecting A_k and B_k |
| code_a_i | input | 12 | Converted A-channel code from the converter core |
| code_b_i | input | 12 | Converted B-channel code from the converter core |
| clr_i | input | 1 | Clears the interrupt flag and the overflow flag |
| adc_clk_o | output | 1 | Derived converter clock |
| sh_o | output | 1 | Sample/hold pulse; sampling happens on its fall |
| pair_o | output | 3 | Latched pair index to the analog multiplexer |
| res_a_o | output | 12 | A-channel result register |
| res_b_o | output | 12 | B-channel result register |
| irq_o | output | 1 | Sticky conversion-complete flag |
| ovf_o | output | 1 | Sticky flag for a request dropped while busy |

## Verification
The bench uses the default parameters: 12-bit codes, a 4-bit acquisition field, result latencies of four and five converter clocks, and an interrupt lag of two clocks. With a 4-bit field, both the narrowest pulse (acq 0) and the widest (acq 15) can be run, and so can continuous runs whose next pulse overlaps the result pipeline of the previous sample. The converter codes change on every clock, so a result taken one cycle early or late shows up as a wrong value. A request placed one edge before the end of the busy window and one placed on the first idle edge check the exact boundary of the busy window.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DELAY,
      ST_HOLD,
      ST_GAP,
      ST_DRAIN
   } seq_st_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adcseq_shgen.sv
module adcseq_shgen
   import adcseq_pkg::*;
#(
   parameter int ACQ_W      = 4,
   parameter int PAIR_W     = 3,
   parameter int DLY_HALF   = 5,
   parameter int GAP_HALF   = 4,
   parameter int DRAIN_HALF = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              cont_i,
   input  logic [ACQ_W-1:0]  acq_i,
   input  logic [PAIR_W-1:0] pair_i,
   input  logic              clr_i,
   output logic              sh_o,
   output logic              samp_o,
   output logic [PAIR_W-1:0] pair_o,
   output logic              ovf_o,
   output logic              adc_clk_o
);

   localparam int HOLD_MAX = 2 << ACQ_W;
   localparam int LEN_MAX  = max_of(max_of(HOLD_MAX, DLY_HALF), max_of(GAP_HALF, DRAIN_HALF));
   localparam int CNT_W    = $clog2(LEN_MAX + 1);

   seq_st_e           st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ACQ_W-1:0]  acq_q;
   logic [PAIR_W-1:0] pair_q;
   logic              samp_q;
   logic              ovf_q;
   logic              aclk_q;
   logic              busy;
   logic              cnt_done;

   function automatic logic [CNT_W-1:0] hold_len(input logic [ACQ_W-1:0] a);
      return CNT_W'(2 * (int'(a) + 1) - 1);
   endfunction

   assign busy     = (st_q != ST_IDLE);
   assign cnt_done = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         acq_q  <= '0;
         pair_q <= '0;
         samp_q <= 1'b0;
      end else begin
         samp_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (trig_i) begin
                  st_q   <= ST_DELAY;
                  cnt_q  <= CNT_W'(DLY_HALF - 1);
                  acq_q  <= acq_i;
                  pair_q <= pair_i;
               end
            end
            ST_DELAY, ST_GAP: begin
               if (cnt_done) begin
                  st_q  <= ST_HOLD;
                  cnt_q <= hold_len(acq_q);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_HOLD: begin
               if (cnt_done) begin
                  samp_q <= 1'b1;
                  if (cont_i) begin
                     st_q   <= ST_GAP;
                     cnt_q  <= CNT_W'(GAP_HALF - 1);
                     acq_q  <= acq_i;
                     pair_q <= pair_i;
                  end else begin
                     st_q  <= ST_DRAIN;
                     cnt_q <= CNT_W'(DRAIN_HALF - 1);
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_DRAIN: begin
               if (cnt_done) st_q <= ST_IDLE;
               else          cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q  <= 1'b0;
         aclk_q <= 1'b0;
      end else begin
         aclk_q <= ~aclk_q;
         if (busy && trig_i) ovf_q <= 1'b1;
         else if (clr_i)     ovf_q <= 1'b0;
      end
   end

   assign sh_o      = (st_q == ST_HOLD);
   assign samp_o    = samp_q;
   assign pair_o    = pair_q;
   assign ovf_o     = ovf_q;
   assign adc_clk_o = aclk_q;

   AST_OVF_ON_BUSY_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && trig_i) |=> ovf_o);                                       // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !clr_i) |=> ovf_o);                                      // R8
   AST_SH_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sh_o) |=> sh_o);                                             // R2
   AST_PAIR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_o && $past(sh_o)) |-> $stable(pair_o));                        // R4
   AST_ADC_CLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_clk_o |=> !adc_clk_o);                                         // R9

endmodule

// File: rtl/adcseq_capture.sv
module adcseq_capture #(
   parameter int DATA_W  = 12,
   parameter int LAT_A   = 8,
   parameter int LAT_B   = 10,
   parameter int IRQ_LAG = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   samp_i,
   input  logic                   clr_i,
   input  logic [1:0][DATA_W-1:0] code_i,
   output logic [DATA_W-1:0]      res_a_o,
   output logic [DATA_W-1:0]      res_b_o,
   output logic                   irq_o
);

   localparam int DEPTH = LAT_B + IRQ_LAG - 1;

   logic [DEPTH-1:0] age_q;
   logic             irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age_q <= '0;
      else        age_q <= {age_q[DEPTH-2:0], samp_i};
   end

   for (genvar g = 0; g < 2; g++) begin : g_ch
      localparam int TAP = ((g == 0) ? LAT_A : LAT_B) - 2;
      logic [DATA_W-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          r_q <= '0;
         else if (age_q[TAP]) r_q <= code_i[g];
      end
   end

   assign res_a_o = g_ch[0].r_q;
   assign res_b_o = g_ch[1].r_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                irq_q <= 1'b0;
      else if (age_q[DEPTH-1])   irq_q <= 1'b1;
      else if (clr_i)            irq_q <= 1'b0;
   end

   assign irq_o = irq_q;

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_i) |=> irq_o);                                      // R7

endmodule

// File: rtl/simul_adc_seq.sv
module simul_adc_seq #(
   parameter int DATA_W       = 12,
   parameter int ACQ_W        = 4,
   parameter int PAIR_W       = 3,
   parameter int TRIG_DLY_HALF = 5,
   parameter int LAT_A_ADC    = 4,
   parameter int LAT_B_ADC    = 5,
   parameter int GAP_ADC      = 2,
   parameter int IRQ_LAG      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_pwm_i,
   input  logic              trig_sw_i,
   input  logic              trig_ext_i,
   input  logic              cont_i,
   input  logic [ACQ_W-1:0]  acq_i,
   input  logic [PAIR_W-1:0] pair_i,
   input  logic [DATA_W-1:0] code_a_i,
   input  logic [DATA_W-1:0] code_b_i,
   input  logic              clr_i,
   output logic              adc_clk_o,
   output logic              sh_o,
   output logic [PAIR_W-1:0] pair_o,
   output logic [DATA_W-1:0] res_a_o,
   output logic [DATA_W-1:0] res_b_o,
   output logic              irq_o,
   output logic              ovf_o
);

   localparam int LAT_A_HALF = 2 * LAT_A_ADC;
   localparam int LAT_B_HALF = 2 * LAT_B_ADC;
   localparam int GAP_HALF   = 2 * GAP_ADC;

   if (ACQ_W < 1 || ACQ_W > 6) begin : g_bad_acq
      $error("ACQ_W out of range");
   end
   if (LAT_A_ADC < 1 || LAT_B_ADC <= LAT_A_ADC) begin : g_bad_lat
      $error("result latencies must be ordered A before B");
   end
   if (IRQ_LAG < 1 || GAP_ADC < 1 || TRIG_DLY_HALF < 1) begin : g_bad_misc
      $error("lag, gap and trigger delay must be positive");
   end

   logic                   trig_any;
   logic                   samp;
   logic [1:0][DATA_W-1:0] codes;

   assign trig_any = trig_pwm_i | trig_sw_i | trig_ext_i;
   assign codes    = {code_b_i, code_a_i};

   adcseq_shgen #(
      .ACQ_W      (ACQ_W),
      .PAIR_W     (PAIR_W),
      .DLY_HALF   (TRIG_DLY_HALF),
      .GAP_HALF   (GAP_HALF),
      .DRAIN_HALF (LAT_B_HALF)
   ) u_shgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_i    (trig_any),
      .cont_i    (cont_i),
      .acq_i     (acq_i),
      .pair_i    (pair_i),
      .clr_i     (clr_i),
      .sh_o      (sh_o),
      .samp_o    (samp),
      .pair_o    (pair_o),
      .ovf_o     (ovf_o),
      .adc_clk_o (adc_clk_o)
   );

   adcseq_capture #(
      .DATA_W  (DATA_W),
      .LAT_A   (LAT_A_HALF),
      .LAT_B   (LAT_B_HALF),
      .IRQ_LAG (IRQ_LAG)
   ) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .samp_i  (samp),
      .clr_i   (clr_i),
      .code_i  (codes),
      .res_a_o (res_a_o),
      .res_b_o (res_b_o),
      .irq_o   (irq_o)
   );

   AST_SAMPLE_ON_SH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sh_o) |-> samp);                                             // R2

endmodule

// File: tb/sim_simul_adc_seq.sv
module sim_simul_adc_seq;
   localparam int DW = 12;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          trig_pwm, trig_sw, trig_ext, cont, clr;
   logic [3:0]    acq;
   logic [2:0]    pair;
   logic [DW-1:0] code_a, code_b;
   logic          adc_clk, sh, irq, ovf;
   logic [2:0]    pair_o;
   logic [DW-1:0] res_a, res_b;

   int n = 0;
   int checks = 0;
   int errors = 0;
   int qa_c[$], qa_v[$], qb_c[$], qb_v[$];

   always #4 clk = ~clk;

   initial forever @(posedge clk) n <= n + 1;

   function automatic logic [DW-1:0] fa(input int k);
      return DW'(k * 7 + 3);
   endfunction
   function automatic logic [DW-1:0] fb(input int k);
      return DW'(k * 13 + 100);
   endfunction

   assign code_a = fa(n);
   assign code_b = fb(n);

   simul_adc_seq u0 (
      .clk(clk), .rst_n(rst_n),
      .trig_pwm_i(trig_pwm), .trig_sw_i(trig_sw), .trig_ext_i(trig_ext),
      .cont_i(cont), .acq_i(acq), .pair_i(pair),
      .code_a_i(code_a), .code_b_i(code_b), .clr_i(clr),
      .adc_clk_o(adc_clk), .sh_o(sh), .pair_o(pair_o),
      .res_a_o(res_a), .res_b_o(res_b), .irq_o(irq), .ovf_o(ovf)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h (t=%0d)", tag, act, exp, n);
      end
   endtask

   // scoreboard monitor: results must appear exactly at the expected count
   initial forever begin
      @(negedge clk);
      if (qa_c.size() > 0 && n >= qa_c[0]) begin
         chk(n == qa_c[0] && res_a == qa_v[0], "R3 res_a", int'(res_a), qa_v[0]);
         void'(qa_c.pop_front()); void'(qa_v.pop_front());
      end
      if (qb_c.size() > 0 && n >= qb_c[0]) begin
         chk(n == qb_c[0] && res_b == qb_v[0], "R3 res_b", int'(res_b), qb_v[0]);
         void'(qb_c.pop_front()); void'(qb_v.pop_front());
      end
   end

   task automatic run(input int src, input int a, input int pr, input int ns,
                      input int end_off, input bit chk_irq, input bit poke);
      int e0, s0, sp, sl;
      sp = 2 * (3 + a);
      e0 = n + 1;
      s0 = e0 + 5 + 2 * (1 + a);
      sl = s0 + (ns - 1) * sp;
      for (int j = 0; j < ns; j++) begin
         qa_c.push_back(s0 + j * sp + 8);  qa_v.push_back(int'(fa(s0 + j * sp + 7)));
         qb_c.push_back(s0 + j * sp + 10); qb_v.push_back(int'(fb(s0 + j * sp + 9)));
      end
      acq = 4'(a); pair = 3'(pr); cont = (ns > 1); clr = 1'b1;
      case (src)
         0:       trig_pwm = 1'b1;
         1:       trig_sw  = 1'b1;
         default: trig_ext = 1'b1;
      endcase
      while (n < sl + end_off) begin
         @(negedge clk);
         trig_pwm = 1'b0; trig_sw = 1'b0; trig_ext = 1'b0; clr = 1'b0;
         if (n == e0 + 1) pair = 3'(pr) ^ 3'd5;
         if (poke && n == e0 + 2) trig_ext = 1'b1;
         if (n == sl - 1) cont = 1'b0;
         if (n == e0) chk(pair_o == 3'(pr), "R4 pair latched", int'(pair_o), pr);
         if (n == e0 + 4) chk(sh == 1'b0, "R1 sh before delay", int'(sh), 0);
         if (n == e0 + 5) chk(sh == 1'b1, "R1 sh after delay", int'(sh), 1);
         if (n == s0 - 1) chk(sh == 1'b1, "R2 sh width end", int'(sh), 1);
         if (n == s0 - 1) chk(pair_o == 3'(pr), "R4 pair held", int'(pair_o), pr);
         if (n == s0)     chk(sh == 1'b0, "R2 sh fall", int'(sh), 0);
         if (n == s0) chk(pair_o == ((ns > 1) ? (3'(pr) ^ 3'd5) : 3'(pr)),
                          "R5 pair relatch", int'(pair_o), (ns > 1) ? (pr ^ 5) : pr);
         if (ns > 1 && n == s0 + 3) chk(sh == 1'b0, "R5 gap low", int'(sh), 0);
         if (ns > 1 && n == s0 + 4) chk(sh == 1'b1, "R5 restart", int'(sh), 1);
         if (poke && n == e0 + 3) chk(ovf == 1'b1, "R8 ovf on busy", int'(ovf), 1);
         if (chk_irq && n == sl + 11) chk(irq == 1'b0, "R7 irq not yet", int'(irq), 0);
         if (chk_irq && n == sl + 12) chk(irq == 1'b1, "R7 irq set", int'(irq), 1);
      end
   endtask

   initial begin
      rst_n = 1'b0; trig_pwm = 1'b0; trig_sw = 1'b0; trig_ext = 1'b0;
      cont = 1'b0; clr = 1'b0; acq = '0; pair = '0;
      repeat (3) @(negedge clk);
      chk(sh == 0 && irq == 0 && ovf == 0, "R10 flags in reset", {sh, irq, ovf}, 0);
      chk(res_a == 0 && res_b == 0, "R10 results in reset", int'(res_a | res_b), 0);
      chk(pair_o == 0, "R10 pair in reset", int'(pair_o), 0);
      chk(adc_clk == 0, "R9 adc clock in reset", int'(adc_clk), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         logic prev;
         prev = adc_clk;
         @(negedge clk);
         chk(adc_clk != prev, "R9 adc clock toggle", int'(adc_clk), int'(!prev));
      end
      run(0, 0, 3, 1, 13, 1'b1, 1'b0);
      run(1, 15, 7, 1, 13, 1'b1, 1'b0);
      run(2, 5, 1, 4, 13, 1'b0, 1'b0);
      run(0, 2, 4, 1, 13, 1'b1, 1'b1);
      chk(ovf == 1'b1, "R8 ovf sticky", int'(ovf), 1);
      chk(irq == 1'b1, "R7 irq sticky", int'(irq), 1);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      chk(ovf == 1'b0, "R8 ovf cleared", int'(ovf), 0);
      chk(irq == 1'b0, "R7 irq cleared", int'(irq), 0);
      // R6: busy window boundary after a single conversion
      run(1, 0, 2, 1, 9, 1'b0, 1'b0);
      trig_sw = 1'b1;
      @(negedge clk);
      trig_sw = 1'b0;
      chk(ovf == 1'b1, "R6 request in drain dropped", int'(ovf), 1);
      chk(sh == 1'b0, "R6 no pulse from dropped request", int'(sh), 0);
      run(2, 3, 6, 3, 13, 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      chk(qa_c.size() == 0 && qb_c.size() == 0, "R3 all results seen",
          qa_c.size() + qb_c.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule